// File: doc/BRIEF.md
# Faulting-Word Trap Monitor

This block is a passive monitor that designates one word of the address space as a location that can never be accessed successfully. It observes two things: the instruction retirement trace of a processor core, and the responses seen on the memory bus. For every retired instruction whose fetch address, load address or store address lands in that word, it checks three things. The instruction must retire as a trap. The cause code must match the kind of access. The trapping instruction must leave no architectural side effect in the trace.

The monitor also checks the bus. Any bus response for the designated word must be marked as a fault. When the optional fault-detail reporting is enabled, a trap on the word must also report a valid fault address that points into that word.

Each kind of violation has its own bit in a combinational error vector. That bit is high in the same cycle as the offending retirement or bus response. Any error also sets a fail flag, which stays high until reset. The monitor is placed next to a core in simulation or emulation and never drives the core.

Top module: `faultword_trap_mon`

## Requirements
- R1: If a retirement has its pc inside the watched word, it must have the trap flag set, cause 1 and an instruction field equal to zero. Otherwise error bit 0 (fetch) is raised.
- R2: A retirement whose opcode (instruction bits 6:0) is 7'b0000011 and whose data access hits the watched word must trap with cause 5. Otherwise error bit 1 (load) is raised.
- R3: A retirement whose opcode is 7'b0100011 (store) or 7'b0101111 (atomic) and whose data access hits the watched word must trap with cause 7. Otherwise error bit 2 (store) is raised.
- R4: Any retirement with the trap flag set must report destination index 0, write-back data 0 and a zero write byte mask. Otherwise error bit 3 (side effect) is raised. A retirement without the trap flag never raises bit 3.
- R5: With EXT_FAULT set, a retirement that hits the word through R1, R2 or R3 must have the fault-detail valid flag set and a fault address inside the watched word. Otherwise error bit 4 (detail) is raised.
- R6: A bus response whose address is inside the watched word must have its fault flag set. Otherwise error bit 5 (bus) is raised. Responses to other addresses are never flagged.
- R7: A data access hits the watched word only when its address is in the word and its attempted byte mask is nonzero. Opcodes other than those named in R2 and R3 have no data check.
- R8: When the pc hits the watched word, the load and store checks are skipped, so only the fetch rule applies to that retirement.
- R9: The error bits depend only on the inputs of the same cycle. Retirement errors require the retirement-valid input, and the bus error requires the bus-valid input.
- R10: The fail flag is 0 after a synchronous reset. It becomes 1 on the clock edge after any error bit is high, and it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | A retirement is reported this cycle |
| ret_pc | input | XLEN | Address the retired instruction was fetched from |
| ret_insn | input | 32 | Retired instruction word |
| ret_trap | input | 1 | Retirement ended in a trap |
| ret_cause | input | 4 | Trap cause code |
| ret_rd_idx | input | 5 | Destination register index |
| ret_rd_wdata | input | XLEN | Destination write-back data |
| ret_mem_addr | input | XLEN | Data access address |
| ret_mem_amask | input | XLEN/8 | Byte lanes the data access attempted |
| ret_mem_wmask | input | XLEN/8 | Byte lanes actually written |
| ret_flt_valid | input | 1 | Fault-detail information is present |
| ret_flt_addr | input | XLEN | Reported faulting address |
| bus_valid | input | 1 | A bus response is observed this cycle |
| bus_addr | input | XLEN | Address of the bus response |
| bus_fault | input | 1 | Bus response carries a fault |
| err_o | output | 6 | Error bits: 0 fetch, 1 load, 2 store, 3 side effect, 4 detail, 5 bus |
| fail_o | output | 1 | Sticky failure flag |

## Verification
The retirement checks and the bus-response check run on independent inputs, so both can report an error in the same cycle. The bench provokes this with a load that hits the word and reports the wrong cause, presented together with a bus response for the word that has no fault flag. It expects bits 1 and 5 together and no other bit. The same two checks are also exercised one at a time, so that a merge that hides one bit behind the other would show up. A later reset confirms that the fail flag latched from such a combined cycle clears normally.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

    localparam int CAUSE_W = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_FLT = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_FLT  = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_FLT = 4'd7;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_AMO   = 7'b0101111;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    // bit 0 is fetch, bit 5 is bus
    typedef struct packed {
        logic bus;
        logic detail;
        logic side;
        logic store;
        logic load;
        logic fetch;
    } err_vec_t;

    function automatic acc_kind_e decode_kind(input logic [6:0] opc);
        acc_kind_e k;
        case (opc)
            OPC_LOAD:           k = ACC_LOAD;
            OPC_STORE, OPC_AMO: k = ACC_STORE;
            default:            k = ACC_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/fwt_word_match.sv
module fwt_word_match #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] WATCH_ADDR = 32'h0000_1000
) (
    input  logic [XLEN-1:0] addr,
    output logic            hit
);
    localparam int              OFS     = $clog2(XLEN / 8);
    localparam logic [XLEN-1:0] HI_MASK = {XLEN{1'b1}} << OFS;

    assign hit = ((addr ^ WATCH_ADDR) & HI_MASK) == '0;
endmodule

// File: rtl/fwt_retire_chk.sv
module fwt_retire_chk
    import fwt_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit EXT_FAULT = 1'b1
) (
    input  logic                 valid,
    input  logic [31:0]          insn,
    input  logic                 trap,
    input  logic [CAUSE_W-1:0]   cause,
    input  logic [4:0]           rd_idx,
    input  logic [XLEN-1:0]      rd_wdata,
    input  logic [XLEN/8-1:0]    wmask,
    input  logic                 pc_hit,
    input  logic                 data_hit,
    input  logic                 flt_valid,
    input  logic                 flt_hit,
    output logic                 e_fetch,
    output logic                 e_load,
    output logic                 e_store,
    output logic                 e_side,
    output logic                 e_detail
);
    acc_kind_e kind;
    logic      ld_hit;
    logic      st_hit;
    logic      any_hit;
    logic      dirty;

    always_comb begin
        kind    = decode_kind(insn[6:0]);
        ld_hit  = !pc_hit && data_hit && (kind == ACC_LOAD);
        st_hit  = !pc_hit && data_hit && (kind == ACC_STORE);
        any_hit = pc_hit || ld_hit || st_hit;
        dirty   = (rd_idx != '0) || (rd_wdata != '0) || (wmask != '0);

        e_fetch = valid && pc_hit &&
                  !(trap && cause == CAUSE_FETCH_FLT && insn == '0);
        e_load  = valid && ld_hit && !(trap && cause == CAUSE_LOAD_FLT);
        e_store = valid && st_hit && !(trap && cause == CAUSE_STORE_FLT);
        e_side  = valid && trap && dirty;
    end

    generate
        if (EXT_FAULT) begin : g_detail
            assign e_detail = valid && any_hit && !(flt_valid && flt_hit);
        end else begin : g_no_detail
            logic unused_detail;
            assign unused_detail = flt_valid ^ flt_hit ^ any_hit;
            assign e_detail = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/fwt_bus_chk.sv
module fwt_bus_chk (
    input  logic valid,
    input  logic hit,
    input  logic fault,
    output logic e_bus
);
    assign e_bus = valid && hit && !fault;
endmodule

// File: rtl/faultword_trap_mon.sv
module faultword_trap_mon
    import fwt_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] WATCH_ADDR = 32'h0000_1000,
    parameter bit              EXT_FAULT  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ret_valid,
    input  logic [XLEN-1:0]    ret_pc,
    input  logic [31:0]        ret_insn,
    input  logic               ret_trap,
    input  logic [CAUSE_W-1:0] ret_cause,
    input  logic [4:0]         ret_rd_idx,
    input  logic [XLEN-1:0]    ret_rd_wdata,
    input  logic [XLEN-1:0]    ret_mem_addr,
    input  logic [XLEN/8-1:0]  ret_mem_amask,
    input  logic [XLEN/8-1:0]  ret_mem_wmask,
    input  logic               ret_flt_valid,
    input  logic [XLEN-1:0]    ret_flt_addr,
    input  logic               bus_valid,
    input  logic [XLEN-1:0]    bus_addr,
    input  logic               bus_fault,
    output logic [5:0]         err_o,
    output logic               fail_o
);
    logic     pc_hit;
    logic     mem_in_word;
    logic     flt_hit;
    logic     bus_hit;
    logic     data_hit;
    err_vec_t errs;
    logic     fail_q;

    fwt_word_match #(.XLEN(XLEN), .WATCH_ADDR(WATCH_ADDR)) u_pc_match (
        .addr (ret_pc),
        .hit  (pc_hit)
    );

    fwt_word_match #(.XLEN(XLEN), .WATCH_ADDR(WATCH_ADDR)) u_mem_match (
        .addr (ret_mem_addr),
        .hit  (mem_in_word)
    );

    fwt_word_match #(.XLEN(XLEN), .WATCH_ADDR(WATCH_ADDR)) u_flt_match (
        .addr (ret_flt_addr),
        .hit  (flt_hit)
    );

    fwt_word_match #(.XLEN(XLEN), .WATCH_ADDR(WATCH_ADDR)) u_bus_match (
        .addr (bus_addr),
        .hit  (bus_hit)
    );

    assign data_hit = mem_in_word && (ret_mem_amask != '0);

    fwt_retire_chk #(.XLEN(XLEN), .EXT_FAULT(EXT_FAULT)) u_retire (
        .valid     (ret_valid),
        .insn      (ret_insn),
        .trap      (ret_trap),
        .cause     (ret_cause),
        .rd_idx    (ret_rd_idx),
        .rd_wdata  (ret_rd_wdata),
        .wmask     (ret_mem_wmask),
        .pc_hit    (pc_hit),
        .data_hit  (data_hit),
        .flt_valid (ret_flt_valid),
        .flt_hit   (flt_hit),
        .e_fetch   (errs.fetch),
        .e_load    (errs.load),
        .e_store   (errs.store),
        .e_side    (errs.side),
        .e_detail  (errs.detail)
    );

    fwt_bus_chk u_bus (
        .valid (bus_valid),
        .hit   (bus_hit),
        .fault (bus_fault),
        .e_bus (errs.bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else if (errs != '0) begin
            fail_q <= 1'b1;
        end
    end

    assign err_o  = errs;
    assign fail_o = fail_q;
endmodule

// File: rtl/fwt_trap_mon_sva.sv
module fwt_trap_mon_sva #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ret_valid,
    input logic [31:0]       ret_insn,
    input logic              ret_trap,
    input logic [3:0]        ret_cause,
    input logic [4:0]        ret_rd_idx,
    input logic [XLEN-1:0]   ret_rd_wdata,
    input logic [XLEN/8-1:0] ret_mem_wmask,
    input logic              bus_valid,
    input logic              bus_fault,
    input logic [5:0]        err_o,
    input logic              fail_o
);
    p_fail_hold_r10: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);

    p_err_sets_fail_r10: assert property (@(posedge clk) disable iff (rst)
        (err_o != 6'd0) |=> fail_o);

    p_fail_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> ($past(err_o) != 6'd0));

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!ret_valid && !bus_valid) |-> (err_o == 6'd0));

    p_bus_faulted_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_fault) |-> !err_o[5]);

    p_untrapped_side_r4: assert property (@(posedge clk) disable iff (rst)
        !ret_trap |-> !err_o[3]);

    p_clean_trap_r4: assert property (@(posedge clk) disable iff (rst)
        (ret_trap && ret_rd_idx == 5'd0 && ret_rd_wdata == '0 &&
         ret_mem_wmask == '0) |-> !err_o[3]);

    p_fetch_ok_r1: assert property (@(posedge clk) disable iff (rst)
        (ret_trap && ret_cause == 4'd1 && ret_insn == 32'd0) |-> !err_o[0]);

    p_kind_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_o[2:0]));
endmodule

bind faultword_trap_mon fwt_trap_mon_sva #(.XLEN(XLEN)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .ret_valid     (ret_valid),
    .ret_insn      (ret_insn),
    .ret_trap      (ret_trap),
    .ret_cause     (ret_cause),
    .ret_rd_idx    (ret_rd_idx),
    .ret_rd_wdata  (ret_rd_wdata),
    .ret_mem_wmask (ret_mem_wmask),
    .bus_valid     (bus_valid),
    .bus_fault     (bus_fault),
    .err_o         (err_o),
    .fail_o        (fail_o)
);

// File: tb/faultword_trap_mon_tb.sv
module faultword_trap_mon_tb;

    typedef struct packed {
        logic        v;
        logic [31:0] pc;
        logic [31:0] insn;
        logic        trap;
        logic [3:0]  cause;
        logic [4:0]  rd;
        logic [31:0] wd;
        logic [31:0] addr;
        logic [3:0]  am;
        logic [3:0]  wm;
        logic        fv;
        logic [31:0] fa;
        logic        bv;
        logic [31:0] ba;
        logic        bf;
        logic [5:0]  exp;
    } vec_t;

    localparam logic [31:0] LW  = 32'h0040_a083;
    localparam logic [31:0] SW  = 32'h0011_2023;
    localparam logic [31:0] AMO = 32'h0811_202f;
    localparam logic [31:0] ADD = 32'h0020_80b3;
    localparam logic [31:0] PC0 = 32'h0000_0200;
    localparam int NV = 21;

    localparam vec_t VECS [NV] = '{
        // 0 R2: proper load fault
        '{1'b1, PC0, LW, 1'b1, 4'd5, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h00},
        // 1 R2: load with wrong cause
        '{1'b1, PC0, LW, 1'b1, 4'd7, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h02},
        // 2 R2: load not trapped
        '{1'b1, PC0, LW, 1'b0, 4'd0, 5'd1, 32'd5, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1002, 1'b0, 32'd0, 1'b0, 6'h02},
        // 3 R3: proper store fault
        '{1'b1, PC0, SW, 1'b1, 4'd7, 5'd0, 32'd0, 32'h1000, 4'h3, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h00},
        // 4 R3: atomic with load cause
        '{1'b1, PC0, AMO, 1'b1, 4'd5, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h04},
        // 5 R4: trapped store still writes bytes
        '{1'b1, PC0, SW, 1'b1, 4'd7, 5'd0, 32'd0, 32'h1000, 4'hf, 4'hf, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h08},
        // 6 R1: proper fetch fault
        '{1'b1, 32'h1002, 32'd0, 1'b1, 4'd1, 5'd0, 32'd0, 32'd0, 4'h0, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h00},
        // 7 R1: fetch fault with nonzero instruction
        '{1'b1, 32'h1000, 32'h13, 1'b1, 4'd1, 5'd0, 32'd0, 32'd0, 4'h0, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h01},
        // 8 R8: pc hit masks the store check
        '{1'b1, 32'h1000, SW, 1'b1, 4'd1, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h01},
        // 9 R5: detail flag missing
        '{1'b1, PC0, LW, 1'b1, 4'd5, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b0, 32'h1000, 1'b0, 32'd0, 1'b0, 6'h10},
        // 10 R5: detail address outside the word
        '{1'b1, PC0, LW, 1'b1, 4'd5, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1004, 1'b0, 32'd0, 1'b0, 6'h10},
        // 11 R7: load to next word
        '{1'b1, PC0, LW, 1'b0, 4'd0, 5'd1, 32'd9, 32'h1004, 4'hf, 4'h0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 6'h00},
        // 12 R7: zero attempted mask
        '{1'b1, PC0, LW, 1'b0, 4'd0, 5'd1, 32'd9, 32'h1000, 4'h0, 4'h0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 6'h00},
        // 13 R7: non-memory opcode
        '{1'b1, PC0, ADD, 1'b0, 4'd0, 5'd1, 32'd9, 32'h1000, 4'hf, 4'h0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 6'h00},
        // 14 R6: unfaulted bus response
        '{1'b0, PC0, 32'd0, 1'b0, 4'd0, 5'd0, 32'd0, 32'd0, 4'h0, 4'h0, 1'b0, 32'd0, 1'b1, 32'h1001, 1'b0, 6'h20},
        // 15 R6: faulted bus response
        '{1'b0, PC0, 32'd0, 1'b0, 4'd0, 5'd0, 32'd0, 32'd0, 4'h0, 4'h0, 1'b0, 32'd0, 1'b1, 32'h1000, 1'b1, 6'h00},
        // 16 R6: bus response to another word
        '{1'b0, PC0, 32'd0, 1'b0, 4'd0, 5'd0, 32'd0, 32'd0, 4'h0, 4'h0, 1'b0, 32'd0, 1'b1, 32'h0ffc, 1'b0, 6'h00},
        // 17 R2 and R6 in one cycle
        '{1'b1, PC0, LW, 1'b1, 4'd7, 5'd0, 32'd0, 32'h1000, 4'hf, 4'h0, 1'b1, 32'h1000, 1'b1, 32'h1000, 1'b0, 6'h22},
        // 18 R9: bad fields without valid
        '{1'b0, 32'h1000, 32'h13, 1'b0, 4'd0, 5'd3, 32'd1, 32'h1000, 4'hf, 4'hf, 1'b0, 32'd0, 1'b0, 32'h1000, 1'b0, 6'h00},
        // 19 R4: unrelated trap with register write
        '{1'b1, PC0, ADD, 1'b1, 4'd2, 5'd3, 32'd0, 32'd0, 4'h0, 4'h0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 6'h08},
        // 20 R4: unrelated trap with write data only
        '{1'b1, PC0, ADD, 1'b1, 4'd2, 5'd0, 32'h80, 32'd0, 4'h0, 4'h0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 6'h08}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        ret_valid;
    logic [31:0] ret_pc;
    logic [31:0] ret_insn;
    logic        ret_trap;
    logic [3:0]  ret_cause;
    logic [4:0]  ret_rd_idx;
    logic [31:0] ret_rd_wdata;
    logic [31:0] ret_mem_addr;
    logic [3:0]  ret_mem_amask;
    logic [3:0]  ret_mem_wmask;
    logic        ret_flt_valid;
    logic [31:0] ret_flt_addr;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic        bus_fault;
    logic [5:0]  err_o;
    logic        fail_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    faultword_trap_mon u_dut (
        .clk           (clk),
        .rst           (rst),
        .ret_valid     (ret_valid),
        .ret_pc        (ret_pc),
        .ret_insn      (ret_insn),
        .ret_trap      (ret_trap),
        .ret_cause     (ret_cause),
        .ret_rd_idx    (ret_rd_idx),
        .ret_rd_wdata  (ret_rd_wdata),
        .ret_mem_addr  (ret_mem_addr),
        .ret_mem_amask (ret_mem_amask),
        .ret_mem_wmask (ret_mem_wmask),
        .ret_flt_valid (ret_flt_valid),
        .ret_flt_addr  (ret_flt_addr),
        .bus_valid     (bus_valid),
        .bus_addr      (bus_addr),
        .bus_fault     (bus_fault),
        .err_o         (err_o),
        .fail_o        (fail_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t x);
        ret_valid     = x.v;
        ret_pc        = x.pc;
        ret_insn      = x.insn;
        ret_trap      = x.trap;
        ret_cause     = x.cause;
        ret_rd_idx    = x.rd;
        ret_rd_wdata  = x.wd;
        ret_mem_addr  = x.addr;
        ret_mem_amask = x.am;
        ret_mem_wmask = x.wm;
        ret_flt_valid = x.fv;
        ret_flt_addr  = x.fa;
        bus_valid     = x.bv;
        bus_addr      = x.ba;
        bus_fault     = x.bf;
    endtask

    task automatic idle();
        drive('{1'b0, 32'd0, 32'd0, 1'b0, 4'd0, 5'd0, 32'd0, 32'd0, 4'h0, 4'h0,
                1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 6'h00});
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset fail", {31'd0, fail_o}, 32'd0);
        check("R9 reset idle err", {26'd0, err_o}, 32'd0);
        rst = 1'b0;

        // R10: a correct fault retirement leaves fail low
        drive(VECS[0]);
        @(negedge clk);
        idle();
        #1;
        check("R10 fail after clean", {31'd0, fail_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check($sformatf("vector %0d err (R1..R9 table)", i), {26'd0, err_o}, {26'd0, VECS[i].exp});
        end
        @(negedge clk);
        idle();
        #1;
        check("R10 fail after table", {31'd0, fail_o}, 32'd1);

        // R10: reset clears, then timing of the latch
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 cleared by reset", {31'd0, fail_o}, 32'd0);
        @(negedge clk);
        drive(VECS[7]);
        #1;
        check("R1 fetch err isolated", {26'd0, err_o}, 32'h01);
        check("R10 fail not yet", {31'd0, fail_o}, 32'd0);
        @(negedge clk);
        idle();
        #1;
        check("R10 fail latched", {31'd0, fail_o}, 32'd1);
        repeat (5) @(negedge clk);
        #1;
        check("R10 fail holds", {31'd0, fail_o}, 32'd1);
        check("R9 idle err", {26'd0, err_o}, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset again", {31'd0, fail_o}, 32'd0);

        finish_run();
    end

endmodule